// File: doc/BRIEF.md
# Transactional Synchronous FIFO

This block is a single-clock FIFO in which both ends work in transactions. A producer may push a run of entries that stay hidden from the consumer until it commits them; if it abandons the run instead, every entry pushed since the last commit disappears and its space is handed back. The consumer works the same way in mirror: entries it pops keep their storage until it commits the pops, and a rollback rewinds it so that the same entries are presented again in their original order.

Both ends use a valid/accept handshake, with a transfer on any clock edge at which both are high. Full, empty and two programmable early-warning flags are provided. When the two commit inputs are tied high the block behaves as an ordinary FIFO with one cycle from push to visibility. Each end holds a committed pointer and a speculative pointer, so a commit or a rollback takes effect in a single cycle whatever the number of entries it covers.

Top module: `txn_fifo`

## Requirements
- R1: After reset the FIFO is empty: `empty`=1, `rd_valid`=0, `full`=0, `wr_accept`=1, `almost_empty`=1, and `almost_full`=1 only when DEPTH is not larger than AF_MARGIN.
- R2: An entry pushed while `wr_commit` is low (or `wr_rollback` is high) is not visible: it does not raise `rd_valid` or clear `empty`.
- R3: With `wr_commit` high and `wr_rollback` low, every pending pushed entry, including one pushed on that same edge, is visible from the next cycle.
- R4: With `wr_rollback` high, every pending pushed entry, including one pushed on that same edge, is discarded and its space is free again from the next cycle.
- R5: When `wr_commit` and `wr_rollback` are both high on one edge, the rollback is performed and the commit has no effect.
- R6: Committed entries are presented on `rd_data` in the order they were pushed, and `rd_data` stays stable while `rd_valid` is high and no pop or read rollback occurs.
- R7: Entries popped but not yet committed still occupy space: popping from a full FIFO without `rd_commit` leaves `full`=1 and `wr_accept`=0.
- R8: With `rd_commit` high and `rd_rollback` low, every pending popped entry, including one popped on that same edge, is released to the producer from the next cycle.
- R9: With `rd_rollback` high, every pending popped entry, including one popped on that same edge, is presented again in the same order; if `rd_commit` is high on the same edge it has no effect.
- R10: `almost_full` is high exactly when DEPTH minus the stored entries (committed, pending-push and pending-pop) is at most AF_MARGIN.
- R11: `almost_empty` is high exactly when the number of committed, not yet popped entries is at most AE_MARGIN.
- R12: `full` is high when all DEPTH slots are occupied; then `wr_accept` is low and an offered entry is not stored.
- R13: With both commit inputs held high and both rollbacks low, the block acts as a plain FIFO: a pushed entry is readable on the next cycle and a popped slot is free on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | WIDTH | Entry offered by the producer |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_accept | output | 1 | FIFO can take an entry (not full) |
| wr_commit | input | 1 | Make all pending pushes visible |
| wr_rollback | input | 1 | Discard all pending pushes |
| rd_data | output | WIDTH | Oldest entry not yet popped |
| rd_valid | output | 1 | A committed entry is available |
| rd_accept | input | 1 | Consumer takes `rd_data` |
| rd_commit | input | 1 | Release all pending pops |
| rd_rollback | input | 1 | Re-present all pending pops |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No committed entry to pop |
| almost_full | output | 1 | Free slots at most AF_MARGIN |
| almost_empty | output | 1 | Poppable entries at most AE_MARGIN |

## Verification
Pushes are made with commit low, commit high, rollback alone, and commit with rollback together; only the commit-alone case may make data appear, which separates the visibility rule from the discard rule and shows which wins. The FIFO is filled to the brim and then popped without commit, with commit, and with rollback, so a design that frees space on pop rather than on commit, or that loses a same-cycle pop in a commit or rollback, shows as a wrong `full`, `almost_full` or `rd_data`. Draining to the last entries tells the almost-empty threshold apart from an off-by-one, and a run with both commits held high confirms plain FIFO timing.

// File: rtl/txn_fifo_pkg.sv
package txn_fifo_pkg;

    // Resolved action of one transactional end on a clock edge
    typedef enum logic [1:0] {
        TXN_HOLD     = 2'd0,
        TXN_COMMIT   = 2'd1,
        TXN_ROLLBACK = 2'd2
    } txn_act_e;

    // Rollback outranks commit on both ends
    function automatic txn_act_e txn_resolve(input logic commit, input logic rollback);
        txn_act_e act;
        act = TXN_HOLD;
        if (rollback) begin
            act = TXN_ROLLBACK;
        end else if (commit) begin
            act = TXN_COMMIT;
        end
        return act;
    endfunction

endpackage

// File: rtl/txn_fifo_side.sv
// One transactional end: speculative head pointer, committed base pointer
// and the number of entries stepped over since the last commit/rollback.
module txn_fifo_side
    import txn_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          commit,
    input  logic          rollback,
    output logic [AW-1:0] head_q,
    output logic [CW-1:0] pend_q,
    output logic [CW-1:0] drop_cnt,
    output logic [CW-1:0] retire_cnt
);

    typedef struct packed {
        logic [AW-1:0] head;
        logic [AW-1:0] base;
        logic [CW-1:0] pend;
    } side_t;

    side_t    st_d, st_q;
    txn_act_e act;
    logic [AW-1:0] head_step;
    logic [CW-1:0] pend_step;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        logic [AW-1:0] n;
        if (p == AW'(DEPTH - 1)) begin
            n = '0;
        end else begin
            n = p + AW'(1);
        end
        return n;
    endfunction

    always_comb begin
        act        = txn_resolve(commit, rollback);
        head_step  = step ? ptr_next(st_q.head) : st_q.head;
        pend_step  = st_q.pend + CW'(step);
        st_d       = st_q;
        drop_cnt   = '0;
        retire_cnt = '0;
        case (act)
            TXN_COMMIT: begin
                st_d.head  = head_step;
                st_d.base  = head_step;
                st_d.pend  = '0;
                retire_cnt = pend_step;
            end
            TXN_ROLLBACK: begin
                st_d.head  = st_q.base;
                st_d.pend  = '0;
                drop_cnt   = pend_step;
            end
            default: begin
                st_d.head  = head_step;
                st_d.pend  = pend_step;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_q = st_q.head;
    assign pend_q = st_q.pend;

    // R4 / R9: a rollback rewinds the head to the committed base
    p_rollback_rewinds_r4_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> (pend_q == '0) && (head_q == $past(st_q.base)));

    // R3 / R8: a commit moves the base up to the head
    p_commit_aligns_r3_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rollback) |=> (pend_q == '0) && (st_q.base == head_q));

    // R12: never more pending entries than slots
    p_pend_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= CW'(DEPTH));

endmodule

// File: rtl/txn_fifo_store.sv
// Register-based storage: one write port, one asynchronous read port.
module txn_fifo_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic             slot_we;
        logic [WIDTH-1:0] slot_d;

        always_comb begin
            slot_we = we && (waddr == AW'(g));
            slot_d  = slot_we ? wdata : slot_q[g];
        end

        always_ff @(posedge clk) begin
            slot_q[g] <= slot_d;
        end
    end

    assign rdata = slot_q[raddr];

endmodule

// File: rtl/txn_fifo_level.sv
// Occupancy bookkeeping and status flags.
module txn_fifo_level #(
    parameter int DEPTH     = 8,
    parameter int CW        = 4,
    parameter int AF_MARGIN = 2,
    parameter int AE_MARGIN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [CW-1:0] wr_drop,
    input  logic [CW-1:0] rd_retire,
    input  logic [CW-1:0] wr_pend,
    input  logic [CW-1:0] rd_pend,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty
);

    localparam int AF_CLAMP = (AF_MARGIN > DEPTH) ? DEPTH : AF_MARGIN;
    localparam int AE_CLAMP = (AE_MARGIN > DEPTH) ? DEPTH : AE_MARGIN;

    typedef struct packed {
        logic [CW-1:0] used;
    } lvl_t;

    lvl_t          lvl_d, lvl_q;
    logic [CW-1:0] free_cnt;
    logic [CW-1:0] avail_cnt;

    always_comb begin
        lvl_d.used = lvl_q.used + CW'(push) - wr_drop - rd_retire;
        free_cnt   = CW'(DEPTH) - lvl_q.used;
        avail_cnt  = lvl_q.used - wr_pend - rd_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign full         = (free_cnt == '0);
    assign empty        = (avail_cnt == '0);
    assign almost_full  = (free_cnt <= CW'(AF_CLAMP));
    assign almost_empty = (avail_cnt <= CW'(AE_CLAMP));

    // R12: occupancy never exceeds the number of slots
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q.used <= CW'(DEPTH));

    // R7: pending pushes and pending pops are part of the occupancy
    p_pending_counted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, wr_pend} + {1'b0, rd_pend}) <= {1'b0, lvl_q.used});

endmodule

// File: rtl/txn_fifo.sv
module txn_fifo
    import txn_fifo_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 8,
    parameter int AF_MARGIN = 2,
    parameter int AE_MARGIN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_valid,
    output logic             wr_accept,
    input  logic             wr_commit,
    input  logic             wr_rollback,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    input  logic             rd_accept,
    input  logic             rd_commit,
    input  logic             rd_rollback,
    output logic             full,
    output logic             empty,
    output logic             almost_full,
    output logic             almost_empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          push, pop;
    logic [AW-1:0] wr_head, rd_head;
    logic [CW-1:0] wr_pend, rd_pend;
    logic [CW-1:0] wr_drop, wr_retire_unused;
    logic [CW-1:0] rd_drop_unused, rd_retire;

    always_comb begin
        wr_accept = !full;
        rd_valid  = !empty;
        push      = wr_valid && wr_accept;
        pop       = rd_valid && rd_accept;
    end

    txn_fifo_side #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_wr_side (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (push),
        .commit     (wr_commit),
        .rollback   (wr_rollback),
        .head_q     (wr_head),
        .pend_q     (wr_pend),
        .drop_cnt   (wr_drop),
        .retire_cnt (wr_retire_unused)
    );

    txn_fifo_side #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_rd_side (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (pop),
        .commit     (rd_commit),
        .rollback   (rd_rollback),
        .head_q     (rd_head),
        .pend_q     (rd_pend),
        .drop_cnt   (rd_drop_unused),
        .retire_cnt (rd_retire)
    );

    txn_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) i_store (
        .clk   (clk),
        .we    (push),
        .waddr (wr_head),
        .wdata (wr_data),
        .raddr (rd_head),
        .rdata (rd_data)
    );

    txn_fifo_level #(
        .DEPTH     (DEPTH),
        .CW        (CW),
        .AF_MARGIN (AF_MARGIN),
        .AE_MARGIN (AE_MARGIN)
    ) i_level (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (push),
        .wr_drop      (wr_drop),
        .rd_retire    (rd_retire),
        .wr_pend      (wr_pend),
        .rd_pend      (rd_pend),
        .full         (full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

    // R6: the presented entry holds while it is not taken and not rewound
    p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_accept && !rd_rollback) |=> (rd_valid && $stable(rd_data)));

    // R2: without an effective write commit nothing becomes visible
    p_invisible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && (!wr_commit || wr_rollback) && !rd_rollback) |=> empty);

    // R7: space held by a full FIFO is released only by a commit of pops or a write rollback
    p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(rd_commit && !rd_rollback) && !wr_rollback) |=> full);

endmodule

// File: tb/test_txn_fifo.sv
module test_txn_fifo;

    localparam int WIDTH = 8;
    localparam int DEPTH = 8;
    localparam int AFM   = 2;
    localparam int AEM   = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             wr_valid = 1'b0;
    logic             wr_accept;
    logic             wr_commit = 1'b0;
    logic             wr_rollback = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             rd_valid;
    logic             rd_accept = 1'b0;
    logic             rd_commit = 1'b0;
    logic             rd_rollback = 1'b0;
    logic             full, empty, almost_full, almost_empty;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    txn_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AF_MARGIN(AFM), .AE_MARGIN(AEM)) i_txn_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_accept(wr_accept),
        .wr_commit(wr_commit), .wr_rollback(wr_rollback),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_accept(rd_accept),
        .rd_commit(rd_commit), .rd_rollback(rd_rollback),
        .full(full), .empty(empty), .almost_full(almost_full), .almost_empty(almost_empty)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one push cycle, inputs applied at negedge, released at the next negedge
    task automatic push(input int d, input bit cm, input bit rb);
        wr_data = WIDTH'(d); wr_valid = 1'b1; wr_commit = cm; wr_rollback = rb;
        @(negedge clk);
        wr_valid = 1'b0; wr_commit = 1'b0; wr_rollback = 1'b0;
    endtask

    // one pop cycle, checking the presented entry first
    task automatic pop(input string req, input int exp, input bit cm, input bit rb);
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check({req, " rd_data"}, int'(rd_data), exp);
        rd_accept = 1'b1; rd_commit = cm; rd_rollback = rb;
        @(negedge clk);
        rd_accept = 1'b0; rd_commit = 1'b0; rd_rollback = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 empty", int'(empty), 1);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 full", int'(full), 0);
        check("R1 wr_accept", int'(wr_accept), 1);
        check("R1 almost_empty", int'(almost_empty), 1);
        check("R1 almost_full", int'(almost_full), 0);
    endtask

    task automatic t_hidden();
        push(10, 0, 0); push(11, 0, 0); push(12, 0, 0);
        check("R2 empty", int'(empty), 1);
        check("R2 rd_valid", int'(rd_valid), 0);
        check("R11 almost_empty pending only", int'(almost_empty), 1);
        check("R10 almost_full free5", int'(almost_full), 0);
        push(13, 1, 0);
        check("R3 rd_valid", int'(rd_valid), 1);
        check("R11 almost_empty avail4", int'(almost_empty), 0);
        pop("R6 first", 10, 1, 0);
        pop("R6 second", 11, 1, 0);
        pop("R6 third", 12, 1, 0);
        check("R11 almost_empty avail1", int'(almost_empty), 1);
        pop("R3 same-cycle push", 13, 1, 0);
        check("R6 empty", int'(empty), 1);
    endtask

    task automatic t_wr_rollback();
        push(20, 0, 0); push(21, 0, 0);
        check("R10 almost_full free6", int'(almost_full), 0);
        push(22, 0, 1);
        check("R4 empty", int'(empty), 1);
        push(30, 1, 1);
        check("R5 empty", int'(empty), 1);
        push(31, 1, 0);
        pop("R4 discarded", 31, 1, 0);
        check("R4 empty after", int'(empty), 1);
        // all space back: eight commits fill exactly to full
        for (int i = 0; i < DEPTH; i++) push(60 + i, 1, 0);
        check("R4 space returned full", int'(full), 1);
        for (int i = 0; i < DEPTH; i++) pop("R4 refill order", 60 + i, 1, 0);
        check("R4 drained", int'(empty), 1);
    endtask

    task automatic t_fill_and_read();
        for (int i = 0; i < DEPTH; i++) begin
            push(40 + i, 1, 0);
            if (i == 4) check("R10 almost_full free3", int'(almost_full), 0);
            if (i == 5) check("R10 almost_full free2", int'(almost_full), 1);
        end
        check("R12 full", int'(full), 1);
        check("R12 wr_accept", int'(wr_accept), 0);
        push(99, 1, 0);
        check("R12 still full", int'(full), 1);
        pop("R7 pop no commit", 40, 0, 0);
        check("R7 full", int'(full), 1);
        check("R7 wr_accept", int'(wr_accept), 0);
        pop("R8 pop with commit", 41, 1, 0);
        check("R8 full", int'(full), 0);
        check("R8 almost_full free2", int'(almost_full), 1);
        // read rollback
        pop("R9 pending a", 42, 0, 0);
        pop("R9 pending b", 43, 0, 1);
        check("R9 rewound", int'(rd_data), 42);
        pop("R9 priority", 42, 1, 1);
        check("R9 rewound again", int'(rd_data), 42);
        check("R9 commit ignored free", int'(almost_full), 1);
        for (int i = 2; i < DEPTH; i++) begin
            if (i == DEPTH - 2) check("R11 almost_empty avail2", int'(almost_empty), 0);
            if (i == DEPTH - 1) check("R11 almost_empty avail1 b", int'(almost_empty), 1);
            pop("R6 order after rollback", 40 + i, 1, 0);
        end
        check("R12 offered entry not stored", int'(empty), 1);
        check("R10 almost_full empty", int'(almost_full), 0);
    endtask

    task automatic t_plain();
        wr_commit = 1'b1; rd_commit = 1'b1;
        wr_data = 8'd50; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        check("R13 visible next cycle", int'(rd_valid), 1);
        check("R13 data", int'(rd_data), 50);
        wr_data = 8'd51; wr_valid = 1'b1; rd_accept = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; rd_accept = 1'b0;
        check("R13 streaming data", int'(rd_data), 51);
        for (int i = 0; i < DEPTH - 1; i++) begin
            wr_data = WIDTH'(70 + i); wr_valid = 1'b1;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        check("R13 full", int'(full), 1);
        rd_accept = 1'b1;
        @(negedge clk);
        rd_accept = 1'b0;
        check("R13 slot free next cycle", int'(wr_accept), 1);
        check("R13 next data", int'(rd_data), 70);
        wr_commit = 1'b0; rd_commit = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hidden();
        t_wr_rollback();
        t_fill_and_read();
        t_plain();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule